// File: doc/BRIEF.md
# Dual-Row DDR Pixel Stream Unpacker

This block sits behind the capture flops of one sensor output bank. On every bank clock cycle it gets two parallel snapshots of the bank's data lines: one taken on the rising edge and one on the falling edge. Each pixel is 10 bits wide and travels on five lines. Half of its bits come on one edge and the other half on the other edge. The lines of one beat carry eight pixels: four adjacent columns of an upper image row and the same four columns of a lower image row.

The block joins the two edge halves into full pixel words. It splits them into an upper-row group and a lower-row group, each ordered by column, and registers them as an eight-pixel output beat. The beat carries a valid strobe, the column index of its leftmost pixel, and line-start and line-end flags. A line sync input arms a new line and resets the column counter. The line ends when the column count reaches a programmable row length. Beats that arrive outside an armed line are dropped, and blanking cycles keep the output strobe low.

Top module: `ddr_pixel_unpacker`

## Requirements
- R1: While reset is asserted, and after it until the first accepted beat, `pix_valid`, `pix_sol` and `pix_eol` are 0.
- R2: Each pixel uses five lines, line k of the pixel with k = 0..4. The rising-edge sample of line k carries pixel bit 2k and the falling-edge sample carries bit 2k+1. This is the default mapping; a parameter swaps the two edges.
- R3: Pixel slot p (p = 0..7) uses input lines [5p+4:5p]. Slots 0..3 are the upper row and slots 4..7 the lower row, each at columns base+0..base+3. The output `top_pix[10i+9:10i]` holds the upper row at column `pix_col`+i, and `bot_pix` holds the lower row in the same way.
- R4: An accepted beat appears on the outputs on the clock edge after the one that samples it.
- R5: The first accepted beat after `line_sync` has column 0. Each later accepted beat of the same line has a column 4 higher than the beat before it.
- R6: `pix_sol` is 1 exactly on the first accepted beat of a line.
- R7: `pix_eol` is 1 on the accepted beat whose column plus 4 reaches or passes `row_len`. Beats after it are dropped until the next `line_sync`.
- R8: A cycle with `beat_valid` low gives `pix_valid` low on the next cycle and leaves the column count unchanged.
- R9: Beats that arrive after reset but before any `line_sync` are dropped.
- R10: `line_sync` in the middle of a line restarts the line. A beat in the same cycle as the sync is accepted with column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_len | input | 12 | Pixels per row, a multiple of 4 |
| line_sync | input | 1 | Arms a new line and resets the column count |
| beat_valid | input | 1 | Captured lines hold a data beat this cycle |
| rise_lines | input | 40 | Rising-edge samples, 5 lines per pixel slot |
| fall_lines | input | 40 | Falling-edge samples, 5 lines per pixel slot |
| pix_valid | output | 1 | Output beat strobe |
| pix_sol | output | 1 | First beat of a line |
| pix_eol | output | 1 | Last beat of a line |
| pix_col | output | 12 | Column of the leftmost pixel in the beat |
| top_pix | output | 40 | Four upper-row pixels, lowest column in the low bits |
| bot_pix | output | 40 | Four lower-row pixels, lowest column in the low bits |

## Verification
The bench serializes ramp pixels into the two edge words. Over four lines the ramp covers all 1024 pixel codes, so a swapped edge or a bit mapped to the wrong line shows up as a wrong word. It also catches a swap between the upper and lower row or a reversed column order. Several line-boundary cases are covered: beats before the first sync, a blank cycle inside a line, a beat after the line end, a sync in a blanking cycle, and a sync in the middle of a line. A design that got any of these wrong would emit a stray strobe, skip or repeat a column, or leave its start and end flags on the wrong beat. The bench models the expected column and line state by arithmetic and compares every beat.

// File: rtl/ddr_unpack_pkg.sv
package ddr_unpack_pkg;
    localparam int PIX_W     = 10;
    localparam int GROUP     = 4;
    localparam int ROWS      = 2;
    localparam int HALF_W    = PIX_W / 2;
    localparam int SLOTS     = GROUP * ROWS;
    localparam int LINE_BITS = SLOTS * HALF_W;
    localparam int COL_W     = 12;
endpackage

// File: rtl/ddr_pix_join.sv
module ddr_pix_join #(
    parameter int PIX_W        = 10,
    parameter bit EVEN_ON_RISE = 1'b1
) (
    input  logic [PIX_W/2-1:0] rise_bits,
    input  logic [PIX_W/2-1:0] fall_bits,
    output logic [PIX_W-1:0]   pix
);
    localparam int HALF_W = PIX_W / 2;

    for (genvar k = 0; k < HALF_W; k++) begin : g_bit
        if (EVEN_ON_RISE) begin : g_even_rise
            assign pix[2*k]   = rise_bits[k];
            assign pix[2*k+1] = fall_bits[k];
        end else begin : g_even_fall
            assign pix[2*k]   = fall_bits[k];
            assign pix[2*k+1] = rise_bits[k];
        end
    end
endmodule

// File: rtl/line_tracker.sv
module line_tracker #(
    parameter int COL_W = 12,
    parameter int GROUP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_valid,
    input  logic             line_sync,
    input  logic [COL_W-1:0] row_len,
    output logic             accept,
    output logic [COL_W-1:0] base_col,
    output logic             is_first,
    output logic             is_last
);
    typedef struct packed {
        logic             active;
        logic [COL_W-1:0] cnt;
    } trk_t;

    trk_t st_d, st_q;
    logic armed;
    logic [COL_W:0] reach;

    always_comb begin
        st_d     = st_q;
        armed    = line_sync | st_q.active;
        base_col = line_sync ? '0 : st_q.cnt;
        accept   = beat_valid & armed;
        reach    = {1'b0, base_col} + (COL_W+1)'(GROUP);
        is_first = (base_col == '0);
        is_last  = (reach >= {1'b0, row_len});
        st_d.active = armed;
        st_d.cnt    = base_col;
        if (accept) begin
            st_d.cnt    = reach[COL_W-1:0];
            st_d.active = ~is_last;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a cycle without a beat leaves the count where it was
    p_hold_on_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_valid && !line_sync) |=> (st_q.cnt == $past(st_q.cnt)));

    // R7: after the last beat, the line stays closed until a sync
    p_closed_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_last) |=> !st_q.active);
endmodule

// File: rtl/ddr_pixel_unpacker.sv
module ddr_pixel_unpacker
    import ddr_unpack_pkg::*;
#(
    parameter int PW       = PIX_W,
    parameter int GRP      = GROUP,
    parameter int CW       = COL_W,
    parameter bit EVEN_RISE = 1'b1,
    localparam int HW      = PW / 2,
    localparam int NSLOT   = GRP * ROWS,
    localparam int LW      = NSLOT * HW,
    localparam int RW      = GRP * PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] row_len,
    input  logic          line_sync,
    input  logic          beat_valid,
    input  logic [LW-1:0] rise_lines,
    input  logic [LW-1:0] fall_lines,
    output logic          pix_valid,
    output logic          pix_sol,
    output logic          pix_eol,
    output logic [CW-1:0] pix_col,
    output logic [RW-1:0] top_pix,
    output logic [RW-1:0] bot_pix
);
    typedef struct packed {
        logic          valid;
        logic          sol;
        logic          eol;
        logic [CW-1:0] col;
        logic [RW-1:0] top;
        logic [RW-1:0] bot;
    } out_t;

    out_t out_d, out_q;
    logic [NSLOT*PW-1:0] joined;
    logic          accept, is_first, is_last;
    logic [CW-1:0] base_col;

    for (genvar p = 0; p < NSLOT; p++) begin : g_slot
        ddr_pix_join #(.PIX_W(PW), .EVEN_ON_RISE(EVEN_RISE)) u_join (
            .rise_bits (rise_lines[p*HW +: HW]),
            .fall_bits (fall_lines[p*HW +: HW]),
            .pix       (joined[p*PW +: PW])
        );
    end

    line_tracker #(.COL_W(CW), .GROUP(GRP)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (beat_valid),
        .line_sync  (line_sync),
        .row_len    (row_len),
        .accept     (accept),
        .base_col   (base_col),
        .is_first   (is_first),
        .is_last    (is_last)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = accept;
        out_d.sol   = accept & is_first;
        out_d.eol   = accept & is_last;
        if (accept) begin
            out_d.col = base_col;
            out_d.top = joined[0 +: RW];
            out_d.bot = joined[RW +: RW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pix_valid = out_q.valid;
    assign pix_sol   = out_q.sol;
    assign pix_eol   = out_q.eol;
    assign pix_col   = out_q.col;
    assign top_pix   = out_q.top;
    assign bot_pix   = out_q.bot;

    // R5: inside a line the column moves by one group per output beat
    p_col_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_sol) |-> (pix_col == $past(pix_col) + CW'(GRP)));

    // R6: a line start always names column zero
    p_sol_col0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_sol) |-> (pix_col == '0));

    // R8: no input beat, no output beat one cycle later
    p_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |=> !pix_valid);

    // R7: after a line end, only a fresh sync lets a beat through
    p_after_eol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_eol) |-> (!out_d.valid || line_sync));

    // R1: flags never stand without the strobe
    p_flags_need_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_sol || pix_eol) |-> pix_valid);
endmodule

// File: tb/sim_ddr_pixel_unpacker.sv
module sim_ddr_pixel_unpacker;
    localparam int LW = 40;
    localparam int RW = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   row_len = 12'd16;
    logic          line_sync = 1'b0;
    logic          beat_valid = 1'b0;
    logic [LW-1:0] rise_lines = '0;
    logic [LW-1:0] fall_lines = '0;
    logic          pix_valid, pix_sol, pix_eol;
    logic [11:0]   pix_col;
    logic [RW-1:0] top_pix, bot_pix;

    int total = 0;
    int bad = 0;
    bit m_active = 1'b0;
    int m_col = 0;

    always #10 clk = ~clk;

    ddr_pixel_unpacker u0 (
        .clk(clk), .rst_n(rst_n), .row_len(row_len), .line_sync(line_sync),
        .beat_valid(beat_valid), .rise_lines(rise_lines), .fall_lines(fall_lines),
        .pix_valid(pix_valid), .pix_sol(pix_sol), .pix_eol(pix_eol),
        .pix_col(pix_col), .top_pix(top_pix), .bot_pix(bot_pix)
    );

    function automatic logic [9:0] ramp(input int line, input int row, input int col);
        return 10'((line * 256 + row * 128 + col) & 1023);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive, let the edge register it, then compare at mid-cycle.
    task automatic beat(input bit v, input bit sync, input int line);
        bit acc;
        int base;
        logic [9:0] px;
        @(negedge clk);
        if (sync) begin
            m_active = 1'b1;
            m_col = 0;
        end
        base = m_col;
        acc = v && m_active;
        for (int p = 0; p < 8; p++) begin
            px = ramp(line, p / 4, base + (p % 4));
            for (int k = 0; k < 5; k++) begin
                rise_lines[p*5+k] = px[2*k];
                fall_lines[p*5+k] = px[2*k+1];
            end
        end
        beat_valid = v;
        line_sync = sync;
        if (acc) begin
            m_col = base + 4;
            if (base + 4 >= int'(row_len)) m_active = 1'b0;
        end
        @(posedge clk);
        #5;
        beat_valid = 1'b0;
        line_sync = 1'b0;
        check("R4/R8/R9 valid", longint'(pix_valid), longint'(acc));
        if (acc) begin
            check("R5 col", longint'(pix_col), longint'(base));
            check("R6 sol", longint'(pix_sol), longint'(base == 0));
            check("R7 eol", longint'(pix_eol), longint'(base + 4 >= int'(row_len)));
            for (int i = 0; i < 4; i++) begin
                check("R2/R3 top", longint'(top_pix[10*i +: 10]), longint'(ramp(line, 0, base + i)));
                check("R2/R3 bot", longint'(bot_pix[10*i +: 10]), longint'(ramp(line, 1, base + i)));
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check("R1 valid in reset", longint'(pix_valid), 0);
        check("R1 sol in reset", longint'(pix_sol), 0);
        check("R1 eol in reset", longint'(pix_eol), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #5;
        check("R1 valid after reset", longint'(pix_valid), 0);

        // R9: beats before the first sync are dropped
        beat(1, 0, 0);
        beat(1, 0, 0);

        // short lines, row_len = 16 -> four beats
        row_len = 12'd16;
        beat(1, 1, 1);
        beat(0, 0, 1);          // R8 blank inside line
        beat(1, 0, 1);
        beat(1, 0, 1);
        beat(1, 0, 1);          // eol
        beat(1, 0, 1);          // R7 dropped after end
        beat(0, 0, 2);
        beat(0, 1, 2);          // sync in blanking
        beat(1, 0, 2);
        beat(1, 0, 2);
        beat(1, 1, 3);          // R10 restart mid-line
        for (int b = 0; b < 4; b++) beat(1, 0, 3);
        beat(1, 0, 3);

        // near-exhaustive sweep of pixel codes: row_len = 128, four lines
        row_len = 12'd128;
        for (int ln = 0; ln < 4; ln++) begin
            beat(0, 0, ln);
            beat(1, 1, ln);
            for (int b = 1; b < 32; b++) begin
                beat(1, 0, ln);
                if (b % 9 == 0) beat(0, 0, ln);
            end
            beat(1, 0, ln);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule